// File: doc/BRIEF.md
# Reloadable Table-Based Constant Multiplier

This block multiplies a small unsigned operand by a constant that software-free control logic can swap at run time. No multiplier sits on the lookup path. Each product bit is read from its own small writable table addressed by the operand, so the lookup path and its wiring never change. Only the table contents change.

When a new constant is requested, a fill sequencer captures it. It then walks through every operand value, one per clock, and writes the truncated product into all bit tables at once. While the refill runs, the block reports itself busy, marks its product as not valid and ignores further requests. Once the refill ends, lookups serve the new constant until the next change.

With the default sizes the operand is 2 bits, the constant 4 bits and the product 4 bits. This gives four 4-entry, 1-bit tables.

Top module: `lutmul_const`

## Requirements
- R1: When `prod_valid_o` is 1, `prod_o` equals (k × a) mod 16. Here k is the last accepted constant and a is the operand sampled at the previous clock edge.
- R2: After loading constant 3, operands 0, 1, 2, 3 give 0, 3, 6, 9. After loading constant 5, they give 0, 5, 10, 15.
- R3: A load request (`load_i` = 1) is accepted only at an edge where `ready_o` is 1. `busy_o` rises right after that edge.
- R4: After acceptance, `busy_o` is 1 for exactly 4 clock cycles, and `ready_o` is always the inverse of `busy_o`.
- R5: `prod_valid_o` is 0 in every cycle where `busy_o` is 1, and also in the first cycle after `busy_o` falls.
- R6: Load requests made while `busy_o` is 1 are ignored. The constant in force after the refill is the one accepted at its start.
- R7: While `rst_n` is 0 at a clock edge, all tables clear, which acts as constant 0. After that edge `busy_o` is 0, `ready_o` is 1, `prod_valid_o` is 0 and `prod_o` is 0.
- R8: The product is registered. A change on `opnd_i` shows on `prod_o` one clock edge later, and `prod_valid_o` is then 1 whenever no refill is in progress.
- R9: A refill replaces every table entry with the truncated product. For example, constant 15 gives operands 0 to 3 the products 0, 15, 14, 13, and no entry from the previous constant survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opnd_i | input | 2 | Operand used as the table address |
| prod_o | output | 4 | Registered product |
| prod_valid_o | output | 1 | Product reflects a complete table set |
| load_i | input | 1 | Request to load a new constant |
| kval_i | input | 4 | Constant to load |
| ready_o | output | 1 | Block can accept a load |
| busy_o | output | 1 | Refill in progress |

## Verification
The bench builds the block with its default sizes: a 2-bit operand, a 4-bit constant and a 4-bit product. At these sizes every operand value and several whole constants, including 0, 3, 5 and 15, can be checked exhaustively against the arithmetic. Truncation of products above 15 and a full four-cycle refill are both covered in a few hundred cycles. Requests made during a refill are probed at its first and its last busy cycle.

// File: rtl/lutmul_pkg.sv
// Shared types for the reloadable table multiplier.
// Assumes nothing beyond a two-state fill sequencer.
package lutmul_pkg;
    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_RUN  = 1'b1
    } fill_state_t;
endpackage

// File: rtl/lutmul_bit_table.sv
// One 1-bit writable lookup table with DEPTH entries.
// It is read combinationally and written synchronously.
// Assumes the writer never writes and resets in the same cycle.
module lutmul_bit_table #(
    parameter int DEPTH = 4,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wdata,
    input  logic [AW-1:0] raddr,
    output logic          rdata
);
    logic [DEPTH-1:0] mem;

    // Hold the table contents: clear on reset, update one entry per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Lookup path: the entry selected by the operand.
    always_comb begin
        rdata = mem[raddr];
    end

    // A written entry holds the written value on the following cycle.
    assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/lutmul_filler.sv
// Fill sequencer. It captures a constant on an accepted request.
// It then steps the table address from 0 up to DEPTH-1, one per clock,
// and drives the truncated product word for that address.
// Assumes PRW <= KW + OPW.
module lutmul_filler
    import lutmul_pkg::*;
#(
    parameter int OPW = 2,
    parameter int KW  = 4,
    parameter int PRW = 4,
    localparam int DEPTH = 1 << OPW,
    localparam int FW    = KW + OPW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic [KW-1:0]  kval_i,
    output logic           busy_o,
    output logic           we_o,
    output logic [OPW-1:0] waddr_o,
    output logic [PRW-1:0] wword_o
);
    localparam logic [OPW-1:0] LAST = OPW'(DEPTH - 1);

    fill_state_t    state;
    logic [OPW-1:0] cnt;
    logic [KW-1:0]  k_q;
    logic [FW-1:0]  full;

    // Sequencer: accept a request when idle, then step through every address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FILL_IDLE;
            cnt   <= '0;
            k_q   <= '0;
        end else begin
            case (state)
                FILL_IDLE: begin
                    if (load_i) begin
                        state <= FILL_RUN;
                        cnt   <= '0;
                        k_q   <= kval_i;
                    end
                end
                FILL_RUN: begin
                    if (cnt == LAST) begin
                        state <= FILL_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= FILL_IDLE;
            endcase
        end
    end

    // Product word for the current address, truncated to the table width.
    always_comb begin
        full    = FW'(k_q) * FW'(cnt);
        wword_o = full[PRW-1:0];
        we_o    = (state == FILL_RUN);
        waddr_o = cnt;
        busy_o  = (state == FILL_RUN);
    end

    // A refill starts only after a request seen while idle.
    assert_start_on_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(load_i));

    // The captured constant stays fixed for the whole refill.
    assert_const_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(k_q));
endmodule

// File: rtl/lutmul_const.sv
// Constant multiplier built from PRW writable 1-bit tables addressed by the
// operand, with a fill sequencer that reloads them when a new constant is
// requested. The product is registered.
// Assumes the operand is held steady by the user while a result is wanted.
module lutmul_const #(
    parameter int OPW = 2,
    parameter int KW  = 4,
    parameter int PRW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] opnd_i,
    output logic [PRW-1:0] prod_o,
    output logic           prod_valid_o,
    input  logic           load_i,
    input  logic [KW-1:0]  kval_i,
    output logic           ready_o,
    output logic           busy_o
);
    localparam int DEPTH = 1 << OPW;
    localparam int RUNW  = $clog2(DEPTH + 1) + 1;

    logic           busy;
    logic           accept;
    logic           we;
    logic [OPW-1:0] waddr;
    logic [PRW-1:0] wword;
    logic [PRW-1:0] lookup;
    logic [PRW-1:0] prod_q;
    logic           valid_q;
    logic [RUNW-1:0] run_len;

    // A request counts only while the block is ready.
    always_comb begin
        accept = load_i && !busy;
    end

    lutmul_filler #(
        .OPW (OPW),
        .KW  (KW),
        .PRW (PRW)
    ) u_filler (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .kval_i  (kval_i),
        .busy_o  (busy),
        .we_o    (we),
        .waddr_o (waddr),
        .wword_o (wword)
    );

    // One table per product bit, all written in parallel.
    for (genvar b = 0; b < PRW; b++) begin : g_bit
        lutmul_bit_table #(
            .DEPTH (DEPTH)
        ) u_tab (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we),
            .waddr (waddr),
            .wdata (wword[b]),
            .raddr (opnd_i),
            .rdata (lookup[b])
        );
    end

    // Output register: capture the lookup; invalid across acceptance and refill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            prod_q  <= lookup;
            valid_q <= !busy && !accept;
        end
    end

    // Length of the current busy run, kept for the refill-length check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (busy_o) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    // Drive the handshake and result ports.
    always_comb begin
        busy_o       = busy;
        ready_o      = !busy;
        prod_o       = prod_q;
        prod_valid_o = valid_q;
    end

    // A refill lasts exactly DEPTH cycles.
    assert_fill_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_len == RUNW'(DEPTH)));

    // A busy run never exceeds DEPTH cycles.
    assert_fill_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= RUNW'(DEPTH));

    // Valid is never shown during a refill.
    assert_valid_not_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        prod_valid_o |-> !busy_o);

    // The cycle right after a refill still reports the result as invalid.
    assert_valid_after_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !prod_valid_o);
endmodule

// File: tb/lutmul_const_bench.sv
// Directed bench for lutmul_const: one task per scenario.
module lutmul_const_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] opnd_i = '0;
    logic [3:0] prod_o;
    logic       prod_valid_o;
    logic       load_i = 1'b0;
    logic [3:0] kval_i = '0;
    logic       ready_o;
    logic       busy_o;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lutmul_const u_lutmul_const (
        .clk          (clk),
        .rst_n        (rst_n),
        .opnd_i       (opnd_i),
        .prod_o       (prod_o),
        .prod_valid_o (prod_valid_o),
        .load_i       (load_i),
        .kval_i       (kval_i),
        .ready_o      (ready_o),
        .busy_o       (busy_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R3 R4 R5: issue a load, check the handshake, and count the busy cycles.
    task automatic do_load(input int k);
        int n;
        kval_i = 4'(k);
        load_i = 1'b1;
        tick();
        load_i = 1'b0;
        check("R3 busy after accept", int'(busy_o), 1);
        check("R5 valid low while busy", int'(prod_valid_o), 0);
        n = 0;
        while (busy_o && n < 10) begin
            check("R4 ready inverse of busy", int'(ready_o), 0);
            n++;
            tick();
        end
        check("R4 busy length", n, 4);
        check("R5 valid low after fill", int'(prod_valid_o), 0);
        tick();
    endtask

    // R1 R8: sweep every operand and compare against (k*a) mod 16.
    task automatic sweep(input string req, input int k);
        for (int a = 0; a < 4; a++) begin
            opnd_i = 2'(a);
            tick();
            check({req, " valid"}, int'(prod_valid_o), 1);
            check(req, int'(prod_o), (k * a) % 16);
        end
    endtask

    // R7: reset state, then constant 0 behaviour.
    task automatic t_reset();
        rst_n = 1'b0;
        opnd_i = 2'd3;
        tick();
        tick();
        check("R7 ready in reset", int'(ready_o), 1);
        check("R7 busy in reset", int'(busy_o), 0);
        check("R7 valid in reset", int'(prod_valid_o), 0);
        check("R7 prod in reset", int'(prod_o), 0);
        rst_n = 1'b1;
        sweep("R7 const zero", 0);
    endtask

    // R2: the two named constants.
    task automatic t_named();
        do_load(3);
        sweep("R2 k3", 3);
        do_load(5);
        sweep("R2 k5", 5);
    endtask

    // R8: latency is one edge; the output tracks a change of operand.
    task automatic t_latency();
        opnd_i = 2'd1;
        tick();
        opnd_i = 2'd2;
        check("R8 before edge", int'(prod_o), 5);
        tick();
        check("R8 after edge", int'(prod_o), 10);
    endtask

    // R6: requests during a refill are ignored, at the first and last busy cycle.
    task automatic t_ignore();
        kval_i = 4'd7;
        load_i = 1'b1;
        tick();
        kval_i = 4'd9;
        tick();
        check("R6 still busy", int'(busy_o), 1);
        load_i = 1'b0;
        tick();
        tick();
        load_i = 1'b1;
        kval_i = 4'd11;
        tick();
        load_i = 1'b0;
        check("R6 fill ended", int'(busy_o), 0);
        check("R6 no restart", int'(ready_o), 1);
        tick();
        check("R6 still idle", int'(busy_o), 0);
        sweep("R6 k7 kept", 7);
    endtask

    // R9: truncation and full replacement of the tables.
    task automatic t_replace();
        do_load(15);
        sweep("R9 k15", 15);
        do_load(0);
        sweep("R9 k0 clears", 0);
        do_load(10);
        sweep("R1 k10", 10);
    endtask

    initial begin
        t_reset();
        t_named();
        t_latency();
        t_ignore();
        t_replace();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule